// File: doc/BRIEF.md
# Urgency-Flag Round-Robin DMA Arbiter

This block picks one winner per cycle among five display DMA pipelines: one graphics channel (index 0), three video channels (indices 1 to 3) and one write-back channel (index 4). Every pipeline drives a request, a priority bit and the current fill level of its buffer. Every pipeline also has its own pair of programmable thresholds. A hysteresis comparator in each pipeline turns the fill level into a local urgency flag. The block ORs all the local flags into one out-of-band urgency line that goes to the interconnect.

A 2-bit mode input switches the urgency mechanism on or off. When it is off, the arbiter rotates among the requesting high-priority pipelines. If none of those is requesting, it rotates among the normal-priority requesters. When it is on, the rotation narrows to the high-priority requesters whose local flag is raised. If there is no such pipeline, the arbiter falls back to the off-mode rule. The grant is registered and is one-hot or all-zero.

Top module: `urg_dma_arbiter`

## Requirements
- R1: After reset the grant is all-zero, the urgency output is low, every local flag is clear and the rotation pointer is at pipeline 0.
- R2: For a high-priority pipeline, a fill level at or below its low threshold sets the local flag on the next clock edge. This also holds when the fill level is at or above the high threshold at the same time, because set wins over clear.
- R3: For a high-priority pipeline, a fill level at or above its high threshold and above its low threshold clears the local flag on the next edge. A fill level strictly between the two thresholds leaves the flag unchanged.
- R4: When a pipeline's priority bit is 0 (normal priority) during a clock edge, its local flag is 0 after that edge.
- R5: With mode 2, the urgency output is the OR of the five registered local flags. It changes in the same cycle as the flags, with no extra register.
- R6: With mode 0, 1 or 3, the urgency output is low.
- R7: Outside mode 2, or in mode 2 when no flagged high-priority pipeline is requesting, the candidates are the requesters with priority bit 1. If there are none, the candidates are all requesters, which are then all normal priority.
- R8: In mode 2, when at least one requesting high-priority pipeline has its local flag raised, only those pipelines are candidates.
- R9: The arbiter scans the candidates upward from the pointer index and wraps from 4 to 0. The first candidate found wins. The pointer then moves to the index after the winner (wrapping 4 to 0). In a cycle with no candidate, the pointer does not change.
- R10: The grant output is one-hot or all-zero. Bit i set means pipeline i wins. The grant appears one cycle after the request and flag state it was decided from, and it never names a pipeline that was not requesting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Urgency mode: 2 means enabled, any other value means disabled |
| req_i | input | 5 | Request per pipeline; bit i is pipeline i |
| prio_i | input | 5 | Priority per pipeline: 1 is high, 0 is normal |
| fill_i | input | 40 | Five 8-bit buffer fill levels; pipeline i uses bits [8i+7:8i] |
| thr_lo_i | input | 40 | Five 8-bit low (set) thresholds, packed the same way |
| thr_hi_i | input | 40 | Five 8-bit high (clear) thresholds, packed the same way |
| gnt_o | output | 5 | Registered grant, one-hot or zero |
| urg_o | output | 1 | Out-of-band urgency line |

## Verification
The assertions assume that all inputs are known and stable at every rising edge. They also assume that requests are sampled every cycle with no handshake, so a requester that loses simply asks again. The bench drives every input at the falling edge only. It picks fill levels close to the thresholds so that the set, clear and hold cases of the hysteresis all occur often. It sometimes draws threshold pairs with the low threshold at or above the high one, to exercise the set-wins rule. The mode input goes through all four codes.

// File: rtl/urg_arb_pkg.sv
package urg_arb_pkg;

    localparam int unsigned PIPE_COUNT = 5;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_RSV1 = 2'd1,
        MODE_ON   = 2'd2,
        MODE_RSV3 = 2'd3
    } urg_mode_e;

endpackage

// File: rtl/urg_hyst_flag.sv
module urg_hyst_flag #(
    parameter int unsigned FILL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prio_i,
    input  logic [FILL_W-1:0] fill_i,
    input  logic [FILL_W-1:0] thr_lo_i,
    input  logic [FILL_W-1:0] thr_hi_i,
    output logic              flag_o
);

    logic flag_d, flag_q;
    logic at_low, at_high;

    always_comb begin
        at_low  = (fill_i <= thr_lo_i);
        at_high = (fill_i >= thr_hi_i);
        flag_d  = flag_q;
        if (!prio_i) begin
            flag_d = 1'b0;
        end else if (at_low) begin
            flag_d = 1'b1;
        end else if (at_high) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_i && (fill_i <= thr_lo_i)) |=> flag_o);

    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_i && (fill_i >= thr_hi_i) && (fill_i > thr_lo_i)) |=> !flag_o);

    assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_i && (fill_i > thr_lo_i) && (fill_i < thr_hi_i)) |=> $stable(flag_o));

    assert_flag_normal_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !prio_i |=> !flag_o);

endmodule

// File: rtl/urg_rr_pick.sv
module urg_rr_pick #(
    parameter int unsigned N     = 5,
    parameter int unsigned PTR_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     cand_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic [N-1:0]     gnt_o,
    output logic [PTR_W-1:0] next_ptr_o,
    output logic             any_o
);

    always_comb begin
        gnt_o      = '0;
        next_ptr_o = ptr_i;
        any_o      = 1'b0;
        for (int k = 0; k < int'(N); k++) begin
            int pos;
            pos = int'(ptr_i) + k;
            if (pos >= int'(N)) begin
                pos = pos - int'(N);
            end
            if (!any_o && cand_i[pos]) begin
                any_o      = 1'b1;
                gnt_o[pos] = 1'b1;
                if (pos == int'(N) - 1) begin
                    next_ptr_o = '0;
                end else begin
                    next_ptr_o = PTR_W'(pos + 1);
                end
            end
        end
    end

endmodule

// File: rtl/urg_dma_arbiter.sv
module urg_dma_arbiter
    import urg_arb_pkg::*;
#(
    parameter int unsigned NUM_PIPE = PIPE_COUNT,
    parameter int unsigned FILL_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 mode_i,
    input  logic [NUM_PIPE-1:0]        req_i,
    input  logic [NUM_PIPE-1:0]        prio_i,
    input  logic [NUM_PIPE*FILL_W-1:0] fill_i,
    input  logic [NUM_PIPE*FILL_W-1:0] thr_lo_i,
    input  logic [NUM_PIPE*FILL_W-1:0] thr_hi_i,
    output logic [NUM_PIPE-1:0]        gnt_o,
    output logic                       urg_o
);

    localparam int unsigned PTR_W = (NUM_PIPE > 1) ? $clog2(NUM_PIPE) : 1;

    typedef struct packed {
        logic [NUM_PIPE-1:0] gnt;
        logic [PTR_W-1:0]    ptr;
    } arb_state_t;

    arb_state_t          st_d, st_q;
    logic [NUM_PIPE-1:0] flag_vec;
    logic [NUM_PIPE-1:0] hi_req, urg_req, cand;
    logic [NUM_PIPE-1:0] pick_gnt;
    logic [PTR_W-1:0]    pick_ptr;
    logic                pick_any;
    logic                mech_on;

    for (genvar g = 0; g < int'(NUM_PIPE); g++) begin : g_pipe
        urg_hyst_flag #(.FILL_W(FILL_W)) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .prio_i   (prio_i[g]),
            .fill_i   (fill_i[g*FILL_W +: FILL_W]),
            .thr_lo_i (thr_lo_i[g*FILL_W +: FILL_W]),
            .thr_hi_i (thr_hi_i[g*FILL_W +: FILL_W]),
            .flag_o   (flag_vec[g])
        );
    end

    always_comb begin
        mech_on = (urg_mode_e'(mode_i) == MODE_ON);
        hi_req  = req_i & prio_i;
        urg_req = hi_req & flag_vec;
        if (mech_on && (urg_req != '0)) begin
            cand = urg_req;
        end else if (hi_req != '0) begin
            cand = hi_req;
        end else begin
            cand = req_i;
        end
    end

    urg_rr_pick #(.N(NUM_PIPE), .PTR_W(PTR_W)) u_pick (
        .cand_i     (cand),
        .ptr_i      (st_q.ptr),
        .gnt_o      (pick_gnt),
        .next_ptr_o (pick_ptr),
        .any_o      (pick_any)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = pick_gnt;
        if (pick_any) begin
            st_d.ptr = pick_ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o = st_q.gnt;
    assign urg_o = mech_on & (|flag_vec);

    assert_gnt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    assert_gnt_from_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_i != '0 |=> (gnt_o != '0) && ((gnt_o & ~$past(req_i)) == '0));

    assert_ptr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cand == '0) |=> $stable(st_q.ptr));

    assert_hi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_req != '0) |=> ((gnt_o & $past(hi_req)) != '0));

    assert_urgent_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mech_on && (urg_req != '0)) |=> ((gnt_o & $past(urg_req)) != '0));

    assert_urg_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mech_on |-> !urg_o);

endmodule

// File: tb/urg_dma_arbiter_bench.sv
module urg_dma_arbiter_bench;

    localparam int N = 5;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     mode = 2'd0;
    logic [N-1:0]   req = '0;
    logic [N-1:0]   prio = '0;
    logic [N*W-1:0] fill = '0;
    logic [N*W-1:0] lo = '0;
    logic [N*W-1:0] hi = '0;
    logic [N-1:0]   gnt;
    logic           urg;

    int total = 0;
    int bad = 0;

    logic [N-1:0] m_flag = '0;
    int           m_ptr = 0;
    logic [N-1:0] m_gnt = '0;
    bit           m_multi = 1'b0;

    always #2 clk = ~clk;

    urg_dma_arbiter u_urg_dma_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .req_i    (req),
        .prio_i   (prio),
        .fill_i   (fill),
        .thr_lo_i (lo),
        .thr_hi_i (hi),
        .gnt_o    (gnt),
        .urg_o    (urg)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] cand_of(logic [N-1:0] r, logic [N-1:0] p,
                                             logic [N-1:0] f, logic [1:0] md);
        logic [N-1:0] h;
        h = r & p;
        if (md == 2'd2 && (h & f) != '0) return h & f;
        if (h != '0) return h;
        return r;
    endfunction

    // Compare outputs, then apply new inputs and advance the model by one edge.
    task automatic step(string urg_tag, logic [1:0] md, logic [N-1:0] rq, logic [N-1:0] pr,
                        logic [N*W-1:0] fl, logic [N*W-1:0] tl, logic [N*W-1:0] th);
        logic [N-1:0] c;
        logic [N-1:0] nf;
        @(negedge clk);
        check(gnt == m_gnt, m_multi ? "R9 R8 R7" : "R7 R8", int'(gnt), int'(m_gnt));
        check($onehot0(gnt), "R10", int'(gnt), int'(m_gnt));
        if (mode == 2'd2)
            check(urg == (|m_flag), urg_tag, int'(urg), int'(|m_flag));
        else
            check(urg == 1'b0, "R6", int'(urg), 0);
        mode = md; req = rq; prio = pr; fill = fl; lo = tl; hi = th;
        c = cand_of(rq, pr, m_flag, md);
        m_multi = ($countones(c) > 1);
        m_gnt = '0;
        for (int k = 0; k < N; k++) begin
            int pos;
            pos = (m_ptr + k) % N;
            if (m_gnt == '0 && c[pos]) begin
                m_gnt[pos] = 1'b1;
                m_ptr = (pos + 1) % N;
            end
        end
        for (int i = 0; i < N; i++) begin
            int f, l, h;
            f = int'(fl[i*W +: W]); l = int'(tl[i*W +: W]); h = int'(th[i*W +: W]);
            if (!pr[i]) nf[i] = 1'b0;
            else if (f <= l) nf[i] = 1'b1;
            else if (f >= h) nf[i] = 1'b0;
            else nf[i] = m_flag[i];
        end
        m_flag = nf;
    endtask

    function automatic logic [N*W-1:0] all_same(int v);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(v);
        return r;
    endfunction

    function automatic logic [N*W-1:0] put(logic [N*W-1:0] base, int idx, int v);
        logic [N*W-1:0] r;
        r = base;
        r[idx*W +: W] = W'(v);
        return r;
    endfunction

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        lo = all_same(40);
        hi = all_same(200);
        fill = all_same(120);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked by the first comparison
        @(negedge clk);
        check(gnt == '0, "R1", int'(gnt), 0);
        check(urg == 1'b0, "R1", int'(urg), 0);

        // Hysteresis walk on pipeline 2 only (R2, R3, R4, R5)
        step("R5", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 100), all_same(40), all_same(200));
        step("R3", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 40),  all_same(40), all_same(200));
        step("R2", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 120), all_same(40), all_same(200));
        step("R3", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 200), all_same(40), all_same(200));
        step("R3", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 120), all_same(40), all_same(200));
        step("R3", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 10),  all_same(40), all_same(200));
        step("R2", 2'd2, 5'b00000, 5'b00000, put(all_same(120), 2, 10),  all_same(40), all_same(200));
        step("R4", 2'd2, 5'b00000, 5'b00100, put(all_same(120), 2, 150), all_same(150), all_same(100));
        step("R2", 2'd2, 5'b00000, 5'b00100, all_same(120), all_same(40), all_same(200));

        // Mode codes with a flag raised (R6)
        for (int md = 0; md < 4; md++)
            step("R5", 2'(md), 5'b00100, 5'b00100, put(all_same(120), 2, 5), all_same(40), all_same(200));

        // Directed arbitration cases (R7, R8, R9)
        step("R5", 2'd0, 5'b11111, 5'b00000, all_same(120), all_same(40), all_same(200));
        repeat (6) step("R5", 2'd0, 5'b11111, 5'b00000, all_same(120), all_same(40), all_same(200));
        repeat (4) step("R5", 2'd0, 5'b11111, 5'b01010, all_same(120), all_same(40), all_same(200));
        step("R5", 2'd2, 5'b11111, 5'b11111, put(all_same(120), 3, 5), all_same(40), all_same(200));
        repeat (4) step("R5", 2'd2, 5'b11111, 5'b11111, put(all_same(120), 3, 5), all_same(40), all_same(200));
        repeat (3) step("R5", 2'd2, 5'b00000, 5'b11111, put(all_same(120), 3, 5), all_same(40), all_same(200));

        // Constrained random
        for (int it = 0; it < 3000; it++) begin
            logic [N*W-1:0] fl, tl, th;
            logic [1:0] md;
            for (int i = 0; i < N; i++) begin
                int l, h, f;
                l = int'($urandom_range(20, 120));
                if ($urandom_range(0, 9) == 0) h = int'($urandom_range(0, l));
                else h = l + int'($urandom_range(1, 100));
                case ($urandom_range(0, 3))
                    0: f = l + int'($urandom_range(0, 2)) - 1;
                    1: f = h + int'($urandom_range(0, 2)) - 1;
                    2: f = int'($urandom_range(l, h));
                    default: f = int'($urandom_range(0, 255));
                endcase
                if (f < 0) f = 0;
                if (f > 255) f = 255;
                if (h > 255) h = 255;
                tl[i*W +: W] = W'(l); th[i*W +: W] = W'(h); fl[i*W +: W] = W'(f);
            end
            md = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd2;
            step("R5", md, N'($urandom), N'($urandom), fl, tl, th);
        end
        step("R5", 2'd0, '0, '0, all_same(120), all_same(40), all_same(200));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule